// File: doc/BRIEF.md
# Start-Vector Loader and Opcode Fetch Sequencer

This block is the bus-facing front end of a small 8-bit processor with a 16-bit address space. When reset is released it reads a two-byte start address from a fixed pair of locations at the top of memory, low byte first. It loads that address into the program counter and then runs an endless loop of opcode fetches. Each instruction takes a fixed pair of bus cycles: the opcode read, then one further read of the byte that follows it.

A decode table built from a bit rule sorts opcodes into two classes. For a single-byte implied instruction the second read is a throw-away: its byte is discarded and the program counter stays put, so the same byte is fetched again as the next opcode. For any other opcode the second byte is consumed as an operand and fetching resumes after it. Read data is captured on the falling clock edge, half a cycle after the address is driven. The state machine consumes it on the following rising edge.

States: `ST_RESET` (idle, held by reset), `ST_VEC_LO` (read vector low byte), `ST_VEC_HI` (read vector high byte, load PC), `ST_FETCH` (opcode read), `ST_DISCARD` (throw-away read after an implied opcode), `ST_OPERAND` (operand read after any other opcode). Transitions: reset → `ST_RESET`; `ST_RESET` → `ST_VEC_LO` → `ST_VEC_HI` → `ST_FETCH`; `ST_FETCH` → `ST_DISCARD` when the captured byte is implied, else → `ST_OPERAND`; `ST_DISCARD` → `ST_FETCH`; `ST_OPERAND` → `ST_FETCH`.

Top module: `fseq_top`

## Requirements
- R1: While `rst` is sampled high, the next cycle shows `bus_rd` low, `op_valid` low and `pc_out` equal to zero.
- R2: The first read after reset is released addresses 16'hFFFC and the very next read addresses 16'hFFFD.
- R3: The first opcode read addresses {byte at 16'hFFFD, byte at 16'hFFFC}, and `pc_out` holds that value during the read.
- R4: From the first vector read onward `bus_rd` stays high every cycle until reset is asserted again.
- R5: `op_valid` is high for exactly one cycle right after each opcode read, with `opcode` equal to the byte read; it is never high in two consecutive cycles.
- R6: Every instruction occupies exactly two bus cycles; the second read addresses the opcode address plus one, and `pc_out` shows that address.
- R7: An opcode is implied (single-byte) when its low nibble is 4'h8, or when its low nibble is 4'hA and bit 7 is set; all others take one operand byte.
- R8: After an implied opcode the second byte is discarded and the next opcode read addresses that same byte.
- R9: After any other opcode the second byte is an operand, and the next opcode read addresses the opcode address plus two.
- R10: The program counter wraps from 16'hFFFF to 16'h0000 with no gap in the fetch stream.
- R11: Asserting reset in the middle of a fetch stream restarts the sequence from the vector reads.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; data captured on the falling edge, state advanced on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| bus_rdata | input | 8 | Read data returned for `bus_addr` |
| bus_addr | output | 16 | Read address of the current bus cycle |
| bus_rd | output | 1 | Read strobe |
| op_valid | output | 1 | One-cycle pulse after each opcode capture |
| opcode | output | 8 | Most recently captured opcode |
| pc_out | output | 16 | Program counter |

## Verification
The bench builds the block with its default parameters: the vector pair at 16'hFFFC/16'hFFFD, 8-bit data and the full 256-entry decode table. Its memory model repeats a sixteen-byte pattern across the whole address space. So one run starting at 16'h8120 walks through implied opcodes, operand-taking opcodes, and operand bytes that would decode as implied. A second run with the vector set to 16'hFFFE brings the program-counter wrap within a few cycles, after a reset in mid-stream.

// File: rtl/fseq_pkg.sv
package fseq_pkg;

    localparam int DATA_W = 8;
    localparam int ADDR_W = 2 * DATA_W;

    typedef enum logic [2:0] {
        ST_RESET,
        ST_VEC_LO,
        ST_VEC_HI,
        ST_FETCH,
        ST_DISCARD,
        ST_OPERAND
    } fseq_state_t;

    // Single-byte implied class: low nibble 8, or low nibble A with bit 7 set.
    function automatic logic op_is_implied(input logic [DATA_W-1:0] op);
        return (op[3:0] == 4'h8) || ((op[3:0] == 4'hA) && op[DATA_W-1]);
    endfunction

endpackage

// File: rtl/fseq_capture.sv
module fseq_capture
    import fseq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rd,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dq
);

    // Read data is taken half a cycle after the address is driven.
    always_ff @(negedge clk) begin
        if (rst) begin
            dq <= '0;
        end else if (rd) begin
            dq <= din;
        end
    end

endmodule

// File: rtl/fseq_decode.sv
module fseq_decode
    import fseq_pkg::*;
(
    input  logic [DATA_W-1:0] op,
    output logic              implied
);

    localparam int N_OPS = 1 << DATA_W;

    logic [N_OPS-1:0] impl_tbl;

    for (genvar i = 0; i < N_OPS; i++) begin : g_tbl
        assign impl_tbl[i] = op_is_implied(DATA_W'(i));
    end

    assign implied = impl_tbl[op];

endmodule

// File: rtl/fseq_ctrl.sv
module fseq_ctrl
    import fseq_pkg::*;
#(
    parameter logic [ADDR_W-1:0] VEC_ADDR = 16'hFFFC
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] rd_byte,
    input  logic              rd_implied,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_rd,
    output logic              op_valid,
    output logic [DATA_W-1:0] opcode,
    output logic [ADDR_W-1:0] pc
);

    localparam logic [ADDR_W-1:0] VEC_ADDR_HI = VEC_ADDR + ADDR_W'(1);

    fseq_state_t       state_q, state_d;
    logic [DATA_W-1:0] vlo_q;

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_RESET;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RESET:   state_d = ST_VEC_LO;
            ST_VEC_LO:  state_d = ST_VEC_HI;
            ST_VEC_HI:  state_d = ST_FETCH;
            ST_FETCH:   state_d = rd_implied ? ST_DISCARD : ST_OPERAND;
            ST_DISCARD: state_d = ST_FETCH;
            ST_OPERAND: state_d = ST_FETCH;
            default:    state_d = ST_RESET;
        endcase
    end

    // Datapath registers
    always_ff @(posedge clk) begin
        if (rst) begin
            pc       <= '0;
            vlo_q    <= '0;
            opcode   <= '0;
            op_valid <= 1'b0;
        end else begin
            op_valid <= (state_q == ST_FETCH);
            unique case (state_q)
                ST_VEC_LO:  vlo_q  <= rd_byte;
                ST_VEC_HI:  pc     <= {rd_byte, vlo_q};
                ST_FETCH: begin
                    opcode <= rd_byte;
                    pc     <= pc + ADDR_W'(1);
                end
                ST_OPERAND: pc     <= pc + ADDR_W'(1);
                default: ;
            endcase
        end
    end

    // Bus outputs
    always_comb begin
        bus_rd   = 1'b1;
        bus_addr = pc;
        unique case (state_q)
            ST_RESET: begin
                bus_rd   = 1'b0;
                bus_addr = '0;
            end
            ST_VEC_LO:  bus_addr = VEC_ADDR;
            ST_VEC_HI:  bus_addr = VEC_ADDR_HI;
            ST_FETCH, ST_DISCARD, ST_OPERAND: bus_addr = pc;
            default: begin
                bus_rd   = 1'b0;
                bus_addr = '0;
            end
        endcase
    end

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        rst |=> (!bus_rd && !op_valid && (pc == '0)));

    // R2
    vec_first_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_rd) |-> (bus_addr == VEC_ADDR));

    // R2
    vec_second_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_rd) |=> (bus_addr == VEC_ADDR_HI));

    // R4
    rd_held_chk: assert property (@(posedge clk) disable iff (rst)
        bus_rd |=> bus_rd);

    // R5
    opv_single_chk: assert property (@(posedge clk) disable iff (rst)
        op_valid |=> !op_valid);

endmodule

// File: rtl/fseq_top.sv
module fseq_top
    import fseq_pkg::*;
#(
    parameter logic [15:0] VEC_ADDR = 16'hFFFC
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [7:0]  bus_rdata,
    output logic [15:0] bus_addr,
    output logic        bus_rd,
    output logic        op_valid,
    output logic [7:0]  opcode,
    output logic [15:0] pc_out
);

    logic [DATA_W-1:0] cap_byte;
    logic              cap_implied;

    fseq_capture u_capture (
        .clk (clk),
        .rst (rst),
        .rd  (bus_rd),
        .din (bus_rdata),
        .dq  (cap_byte)
    );

    fseq_decode u_decode (
        .op      (cap_byte),
        .implied (cap_implied)
    );

    fseq_ctrl #(
        .VEC_ADDR (VEC_ADDR)
    ) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .rd_byte    (cap_byte),
        .rd_implied (cap_implied),
        .bus_addr   (bus_addr),
        .bus_rd     (bus_rd),
        .op_valid   (op_valid),
        .opcode     (opcode),
        .pc         (pc_out)
    );

    // R8
    implied_refetch_chk: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_is_implied(opcode)) |=> (bus_addr == $past(bus_addr)));

    // R9
    operand_skip_chk: assert property (@(posedge clk) disable iff (rst)
        (op_valid && !op_is_implied(opcode)) |=> (bus_addr == $past(bus_addr) + 16'd1));

    // R6
    second_read_chk: assert property (@(posedge clk) disable iff (rst)
        op_valid |-> (bus_rd && (bus_addr == $past(bus_addr) + 16'd1)));

endmodule

// File: tb/fseq_top_bench.sv
module fseq_top_bench;

    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic        rd;
        logic [15:0] addr;
        logic        opv;
        logic [7:0]  op;
        logic [15:0] pc;
        logic [23:0] tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] vec_val = 16'h8120;
    logic [7:0]  bus_rdata;
    logic [15:0] bus_addr;
    logic        bus_rd;
    logic        op_valid;
    logic [7:0]  opcode;
    logic [15:0] pc_out;

    int   n_checks = 0;
    int   n_fails  = 0;
    exp_t exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] pattern(input logic [3:0] i);
        case (i)
            4'h0: return 8'hEA;  4'h1: return 8'hA9;
            4'h2: return 8'hE8;  4'h3: return 8'h18;
            4'h4: return 8'h0A;  4'h5: return 8'h55;
            4'h6: return 8'hAA;  4'h7: return 8'h8A;
            4'h8: return 8'hC8;  4'h9: return 8'h20;
            4'hA: return 8'h9A;  4'hB: return 8'h28;
            4'hC: return 8'h1A;  4'hD: return 8'h7A;
            4'hE: return 8'hE8;  default: return 8'h38;
        endcase
    endfunction

    function automatic logic [7:0] mem(input logic [15:0] a);
        if (a == 16'hFFFC) return vec_val[7:0];
        if (a == 16'hFFFD) return vec_val[15:8];
        return pattern(a[3:0]);
    endfunction

    // R7 rule, restated from the requirement
    function automatic logic ref_implied(input logic [7:0] op);
        return (op[3:0] == 4'h8) || (op[3:0] == 4'hA && op[7] == 1'b1);
    endfunction

    assign bus_rdata = mem(bus_addr);

    fseq_top u_fseq_top (
        .clk       (clk),
        .rst       (rst),
        .bus_rdata (bus_rdata),
        .bus_addr  (bus_addr),
        .bus_rd    (bus_rd),
        .op_valid  (op_valid),
        .opcode    (opcode),
        .pc_out    (pc_out)
    );

    task automatic chk(input logic [23:0] tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    endtask

    // Driver: queue the expected bus trace for one run from reset release.
    task automatic plan_run(input logic [15:0] v, input int n_instr, input logic [23:0] vtag);
        logic [15:0] pc;
        logic [7:0]  op;
        logic        prev_impl;
        logic [23:0] ftag;
        exp_t        e;
        e = '{rd: 1'b1, addr: 16'hFFFC, opv: 1'b0, op: 8'h00, pc: 16'h0000, tag: vtag};
        exp_q.push_back(e);
        e.addr = 16'hFFFD;
        exp_q.push_back(e);
        pc = v;
        prev_impl = 1'b0;
        for (int k = 0; k < n_instr; k++) begin
            if (k == 0)          ftag = "R3";
            else if (prev_impl)  ftag = "R8";
            else                 ftag = "R9";
            e = '{rd: 1'b1, addr: pc, opv: 1'b0, op: 8'h00, pc: pc, tag: ftag};
            exp_q.push_back(e);
            op = mem(pc);
            pc = pc + 16'd1;
            e = '{rd: 1'b1, addr: pc, opv: 1'b1, op: op, pc: pc,
                  tag: (pc == 16'h0000) ? "R10" : "R6"};
            exp_q.push_back(e);
            prev_impl = ref_implied(op);
            if (!prev_impl) pc = pc + 16'd1;
        end
    endtask

    // Monitor: pop one expected item per cycle while out of reset.
    initial begin
        exp_t e;
        forever begin
            @(posedge clk);
            #2;
            if (!rst && exp_q.size() > 0) begin
                e = exp_q.pop_front();
                chk("R4", "bus_rd", 32'(bus_rd), 32'(e.rd));
                chk(e.tag, "bus_addr", 32'(bus_addr), 32'(e.addr));
                chk(e.tag, "pc_out", 32'(pc_out), 32'(e.pc));
                chk("R5", "op_valid", 32'(op_valid), 32'(e.opv));
                if (e.opv) chk("R5", "opcode", 32'(opcode), 32'(e.op));
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        #2;
        chk("R1", "bus_rd", 32'(bus_rd), 32'd0);
        chk("R1", "op_valid", 32'(op_valid), 32'd0);
        chk("R1", "pc_out", 32'(pc_out), 32'd0);

        // Run 1: vector 16'h8120, mixed implied and operand opcodes (R2, R7)
        plan_run(16'h8120, 14, "R2");
        @(negedge clk) rst = 1'b0;
        while (exp_q.size() != 0) @(posedge clk);

        // R11: reset mid-stream
        @(negedge clk) rst = 1'b1;
        @(posedge clk);
        #2;
        chk("R11", "bus_rd", 32'(bus_rd), 32'd0);
        chk("R11", "pc_out", 32'(pc_out), 32'd0);
        chk("R1", "op_valid", 32'(op_valid), 32'd0);

        // Run 2: vector 16'hFFFE forces the wrap (R10)
        vec_val = 16'hFFFE;
        plan_run(16'hFFFE, 12, "R11");
        @(negedge clk) rst = 1'b0;
        while (exp_q.size() != 0) @(posedge clk);

        repeat (2) @(posedge clk);
        report();
    end

endmodule